// File: doc/BRIEF.md
# Sequential Unsigned Shift-Add Multiplier

This block forms the full-width product of two unsigned N-bit operands. It settles one multiplier bit per clock. A start pulse captures the two operands, and the block then spends exactly N clocks in a busy phase. In each of those clocks the multiplicand is added to an accumulator when the low multiplier bit is set. The adder's carry, the accumulator and the multiplier register then shift right together as one value.

After the last shift, a one-cycle done pulse marks the product as valid. The product is the accumulator (upper half) joined to the multiplier register (lower half). It stays unchanged until the next accepted start. Only one multiplication runs at a time, and a start that arrives while the block is busy has no effect.

The operand width is a parameter (default 4). A second parameter selects how the adder is built: an explicit ripple-carry chain or a plain behavioural sum.

Top module: `shmul_seq_mult`

## Requirements
- R1: After a synchronous active-high reset, busy is 0, done is 0 and the product is all zeros.
- R2: A start pulse while idle captures both operands and clears the accumulator, and busy reads 1 from the next cycle.
- R3: In each iteration the multiplicand is added only when the multiplier LSB is 1; otherwise the accumulator only shifts.
- R4: The carry out of each addition enters the accumulator MSB, so all-ones operands produce (2^N-1)^2 with no lost bit (225 for N=4).
- R5: Busy stays 1 for exactly N cycles after the start edge, and done follows in the cycle after the last shift.
- R6: The product is the accumulator in bits [2N-1:N] joined to the multiplier register in bits [N-1:0]; for N=4, 1101 times 1011 gives 10001111 (143).
- R7: Done is high for exactly one cycle, and busy is 0 in that cycle.
- R8: A start pulse while busy is ignored: the result and the timing of the running multiplication are unchanged.
- R9: After done, the product holds its value until the next accepted start, whatever the operand inputs do.
- R10: A zero operand on either side yields a zero product.
- R11: A reset during a multiplication returns the block to idle with done low, and the next start then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| mcand | input | N | Multiplicand operand |
| mplier | input | N | Multiplier operand |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 2N | Unsigned product |

## Verification
A corrupted iteration count shows up at the ports at once as a busy phase of the wrong length, so the position of done is checked in every run. A dropped carry or a misrouted shift bit corrupts the upper product bits, and this appears in the done cycle as a wrong value for products with large operands. Every operand pair for the default width is therefore compared with the arithmetic product. A control state that accepts a start while busy would reload the operands, and the effect is visible only at done, as a product of the wrong operands. A datapath that keeps shifting after done shows up one cycle later, when the held product drifts.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } shmul_state_e;
endpackage

// File: rtl/shmul_adder.sv
// Unsigned N-bit adder with carry out; variant picked by parameter.
module shmul_adder #(
   parameter int N      = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [N-1:0] op_a,
   input  logic [N-1:0] op_b,
   output logic [N:0]   sum
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [N:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign sum[i]  = op_a[i] ^ op_b[i] ^ cy[i];
            assign cy[i+1] = (op_a[i] & op_b[i]) | (cy[i] & (op_a[i] ^ op_b[i]));
         end
         assign sum[N] = cy[N];
      end else begin : g_behav
         assign sum = {1'b0, op_a} + {1'b0, op_b};
      end
   endgenerate

   always_comb begin
      if (!$isunknown({op_a, op_b}))
         AST_ADDER_CARRY_KEPT: assert (32'(sum) == 32'(op_a) + 32'(op_b)); // R4
   end
endmodule

// File: rtl/shmul_ctrl.sv
// Sequencer: idle/run state, iteration counter and done pulse.
module shmul_ctrl
   import shmul_pkg::*;
#(
   parameter int N = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic iterate,
   output logic busy,
   output logic done
);
   localparam int CW = (N > 2) ? $clog2(N) : 1;

   shmul_state_e   state;
   logic [CW-1:0]  cnt;
   logic           done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_RUN;
                  cnt   <= CW'(N - 1);
               end
            end
            ST_RUN: begin
               if (cnt == '0) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign load    = (state == ST_IDLE) && start;
   assign iterate = (state == ST_RUN);
   assign busy    = iterate;
   assign done    = done_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R7
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy))); // R5
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (busy && start && cnt != '0) |=> busy); // R8
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1)); // R5
endmodule

// File: rtl/shmul_datapath.sv
// Multiplicand register, accumulator and multiplier register (A:Q shifter).
module shmul_datapath #(
   parameter int N      = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           iterate,
   input  logic [N-1:0]   mcand_in,
   input  logic [N-1:0]   mplier_in,
   output logic [2*N-1:0] product
);
   logic [N-1:0] m_q;
   logic [N-1:0] a_q;
   logic [N-1:0] q_q;
   logic [N-1:0] addend;
   logic [N:0]   sum;
   logic         carry;

   assign addend = q_q[0] ? m_q : '0;

   shmul_adder #(.N(N), .RIPPLE(RIPPLE)) adder_i (
      .op_a (a_q),
      .op_b (addend),
      .sum  (sum)
   );

   assign carry = sum[N];

   always_ff @(posedge clk) begin
      if (rst) begin
         m_q <= '0;
         a_q <= '0;
         q_q <= '0;
      end else if (load) begin
         m_q <= mcand_in;
         q_q <= mplier_in;
         a_q <= '0;
      end else if (iterate) begin
         a_q <= {carry, sum[N-1:1]};
         q_q <= {sum[0], q_q[N-1:1]};
      end
   end

   assign product = {a_q, q_q};

   AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
      load |=> (a_q == '0)); // R2
   AST_NO_ADD_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
      (iterate && !q_q[0]) |=> (a_q == ($past(a_q) >> 1))); // R3
   AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && !iterate) |=> $stable(product)); // R9
endmodule

// File: rtl/shmul_seq_mult.sv
// Top: sequential unsigned shift-add multiplier.
module shmul_seq_mult #(
   parameter int N            = 4,
   parameter bit ADDER_RIPPLE = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [N-1:0]   mcand,
   input  logic [N-1:0]   mplier,
   output logic           busy,
   output logic           done,
   output logic [2*N-1:0] product
);
   generate
      if (N < 2) begin : g_bad_width
         $error("shmul_seq_mult: N must be at least 2");
      end
   endgenerate

   logic load;
   logic iterate;

   shmul_ctrl #(.N(N)) ctrl_i (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .load    (load),
      .iterate (iterate),
      .busy    (busy),
      .done    (done)
   );

   shmul_datapath #(.N(N), .RIPPLE(ADDER_RIPPLE)) dp_i (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .iterate   (iterate),
      .mcand_in  (mcand),
      .mplier_in (mplier),
      .product   (product)
   );

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(busy && done)); // R7
endmodule

// File: tb/shmul_seq_mult_tb_top.sv
module shmul_seq_mult_tb_top;
   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [N-1:0]   mcand = '0;
   logic [N-1:0]   mplier = '0;
   logic           busy;
   logic           done;
   logic [2*N-1:0] product;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   shmul_seq_mult #(.N(N)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .mcand   (mcand),
      .mplier  (mplier),
      .busy    (busy),
      .done    (done),
      .product (product)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Full run; optional extra start pulse mid-run with other operands.
   task automatic run_mult(input logic [N-1:0] a, input logic [N-1:0] b, input bit inject, input string req);
      logic [2*N-1:0] exp;
      exp = (2*N)'(a) * (2*N)'(b);
      @(negedge clk);
      start = 1'b1; mcand = a; mplier = b;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < N; i++) begin
         chk(busy == 1'b1 && done == 1'b0, "R5 busy phase", {busy, done}, 2'b10);
         if (inject && i == 0) begin
            start = 1'b1; mcand = ~a; mplier = ~b;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1 && busy == 1'b0, "R7 done cycle", {busy, done}, 2'b01);
      chk(product == exp, req, product, exp);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single", done, 0);
      chk(product == exp, "R9 hold", product, exp);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(busy == 0 && done == 0 && product == 0, "R1 reset state", {busy, done, product}, 0);
   endtask

   task automatic t_start_loads;
      @(negedge clk);
      start = 1'b1; mcand = 4'd9; mplier = 4'd6;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      chk(product[2*N-1:N] == 0, "R2 accumulator cleared", product[2*N-1:N], 0);
      chk(product[N-1:0] == 4'd6, "R2 multiplier loaded", product[N-1:0], 6);
      repeat (N + 1) @(negedge clk);
      chk(product == 8'd54, "R2 R3 9x6", product, 54);
   endtask

   task automatic t_exhaustive;
      for (int a = 0; a < (1 << N); a++)
         for (int b = 0; b < (1 << N); b++)
            run_mult(N'(a), N'(b), 1'b0, "R3 R6 exhaustive product");
   endtask

   task automatic t_hold;
      run_mult(4'd7, 4'd12, 1'b0, "R9 setup 7x12");
      for (int i = 0; i < 5; i++) begin
         mcand = N'(i); mplier = N'(i + 3);
         @(negedge clk);
         chk(product == 8'd84 && busy == 0, "R9 product held", product, 84);
      end
   endtask

   task automatic t_reset_mid;
      @(negedge clk);
      start = 1'b1; mcand = 4'd15; mplier = 4'd15;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(busy == 0 && done == 0, "R11 idle after reset", {busy, done}, 0);
      @(negedge clk);
      chk(busy == 0 && done == 0, "R11 stays idle", {busy, done}, 0);
      run_mult(4'd5, 4'd3, 1'b0, "R11 run after reset");
   endtask

   initial begin
      t_reset();
      run_mult(4'b1101, 4'b1011, 1'b0, "R6 13x11");
      run_mult(4'hF, 4'hF, 1'b0, "R4 15x15 carry");
      run_mult(4'd0, 4'd13, 1'b0, "R10 zero multiplicand");
      run_mult(4'd11, 4'd0, 1'b0, "R10 zero multiplier");
      t_start_loads();
      run_mult(4'd10, 4'd13, 1'b1, "R8 start while busy ignored");
      t_hold();
      t_reset_mid();
      t_exhaustive();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule